// File: doc/BRIEF.md
# Gated Elapsed-Time Counter with Shadow Registers

This block keeps a running total of the time during which a chosen condition held. A live counter with 12 fractional bits and 32 seconds bits advances by one on each 4096 Hz tick, but only while the selected run condition is true. The four run conditions are: always, while an event input sits at its active level with main power good, while on main power, and while on battery. Software never touches the live counter directly. All reads and writes go through a byte-addressed shadow copy.

The shadow copy follows the live counter while the transfer-enable input is 1. It holds still while that input is 0, so software can read a consistent value. To load a new time, software drops transfer-enable, writes the time bytes into the shadow copy, and raises transfer-enable again. The next internal update then copies the shadow into the live counter.

Every accepted tick starts an update-in-progress window that lasts a fixed number of clock cycles. The update itself lands on the cycle in which that window closes. The window length is `CLK_MHZ * GUARD_US` cycles, so a zero on the status line promises at least `GUARD_US` microseconds with no update.

The access port uses a valid/ready handshake. A request is taken on a cycle when `acc_valid` and `acc_ready` are both high. `acc_ready` drops for exactly one cycle, the update cycle, so an access never collides with an update. While `acc_ready` is low the requester must hold its request. Read data comes back on `rd_valid`/`rd_data` one cycle after the read is taken; that return path has no back-pressure.

All inputs are assumed to be synchronous to `clk`.

Top module: `etime_core`

## Requirements
- R1: After reset the live counter and the shadow copy are zero, and `uip`, `rd_valid` and `sqws` are 0.
- R2: In run mode 00, each update adds one to the live counter, whatever the power and event inputs are. Updates wrap the counter, and nothing else changes it except a commit.
- R3: In run mode 01, an update counts only when `pwr_fail` is 0 and `event_in` equals `event_pol`. With `event_pol`=1 the event input is active high; with `event_pol`=0 it is active low.
- R4: Run mode 10 counts only when `on_batt` is 0. Run mode 11 counts only when `on_batt` is 1.
- R5: `uip` rises on the cycle after a tick is accepted and stays high for `CLK_MHZ*GUARD_US` cycles. The update becomes visible as `uip` falls. A tick that arrives while `uip` is high is dropped.
- R6: While `xfer_en` is 1, each update loads the new live value into the shadow copy. While `xfer_en` is 0, the shadow copy does not change on updates.
- R7: The register map, by address:
  - 0 reads {fraction bits 3:0, 3'b000, sync bit}.
  - 1 reads fraction bits 11:4.
  - 2 to 5 read seconds bytes, least significant first.
  - 6 and 7 read 0.
  - Read data is valid one cycle after the read is accepted.
- R8: A write to addresses 0–5 while `xfer_en` is 0 changes the addressed shadow bits at once, and a read returns the new value. The same write while `xfer_en` is 1 leaves the time unchanged.
- R9: After such writes, the first update with `xfer_en` 1 loads the live counter with the shadow value, with no increment on that update. Counting then continues from that value.
- R10: `acc_ready` is 0 only during the update cycle, which is the last cycle that `uip` is high.
- R11: The 44-bit count wraps from all ones to zero.
- R12: Bit 0 of a write to address 0 sets the `sqws` output whatever `xfer_en` is. It is never part of the time value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 4096 Hz tick enable |
| pwr_fail | input | 1 | Main supply below fail threshold |
| on_batt | input | 1 | Device running from battery |
| event_in | input | 1 | External event level |
| cfg_mode | input | 2 | Run condition select (00 always, 01 event, 10 mains, 11 battery) |
| event_pol | input | 1 | Active level of `event_in` in mode 01 |
| xfer_en | input | 1 | Shadow refresh enable / commit trigger |
| acc_valid | input | 1 | Register access request |
| acc_ready | output | 1 | Access can be taken this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |
| uip | output | 1 | Update in progress |
| sqws | output | 1 | Square-wave sync control bit |

## Verification
The bench targets several corner cases, each paired with how a wrong design would show it.
- Counting modes: the bench runs each mode with the condition both true and false. It also runs event mode with power failed and the event active. A design that ignores polarity or power fail would show an extra count.
- Second tick while busy: a tick sent while `uip` is high must be dropped. A design that queues or restarts would add two counts or shift the update.
- Freeze and commit: the bench checks that the shadow copy stays frozen while `xfer_en` is 0. A broken commit would increment on the load, or would leave the live counter untouched.
- Wrap, sync bit and write gating: the bench loads all ones and ticks once to check the 44-bit wrap. It toggles the sync bit with `xfer_en` high to check that the write is gated.

// File: rtl/etime_pkg.sv
package etime_pkg;
  typedef enum logic [1:0] {
    RUN_ALWAYS = 2'b00,
    RUN_EVENT  = 2'b01,
    RUN_MAINS  = 2'b10,
    RUN_BATT   = 2'b11
  } run_mode_e;

  localparam int unsigned FRAC_W    = 12;
  localparam int unsigned FRAC_LO_W = FRAC_W - 8;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FIRST_SEC_ADDR = 2;
endpackage

// File: rtl/etime_gate.sv
module etime_gate
  import etime_pkg::*;
(
  input  run_mode_e mode_i,
  input  logic      event_pol_i,
  input  logic      event_i,
  input  logic      pwr_fail_i,
  input  logic      on_batt_i,
  output logic      run_o
);
  always_comb begin
    unique case (mode_i)
      RUN_ALWAYS: run_o = 1'b1;
      RUN_EVENT:  run_o = !pwr_fail_i && (event_i == event_pol_i);
      RUN_MAINS:  run_o = !on_batt_i;
      RUN_BATT:   run_o = on_batt_i;
      default:    run_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/etime_uip.sv
module etime_uip #(
  parameter  int unsigned LEAD = 15000,
  localparam int unsigned CW   = $clog2(LEAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic uip_o,
  output logic fire_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (tick_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(LEAD - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign uip_o  = busy_q;
  assign fire_o = busy_q && (cnt_q == '0);

  AST_UIP_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_o) |-> $past(tick_i)); // R5
  AST_UIP_FALL_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !uip_o); // R5
endmodule

// File: rtl/etime_regs.sv
module etime_regs
  import etime_pkg::*;
#(
  parameter  int unsigned SEC_BYTES = 4,
  parameter  int unsigned ADDR_W    = 3,
  localparam int unsigned CNT_W     = FRAC_W + BYTE_W * SEC_BYTES,
  localparam int unsigned N_REGS    = FIRST_SEC_ADDR + SEC_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              run_i,
  input  logic              xfer_en_i,
  input  logic              acc_fire_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [BYTE_W-1:0] acc_wdata_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              sqws_o
);
  logic [CNT_W-1:0]  live_q, shadow_q, live_nx;
  logic              pend_q, sqws_q, wr_time, commit;
  logic [BYTE_W-1:0] rd_mux;

  assign live_nx = live_q + CNT_W'(run_i);
  assign wr_time = acc_fire_i && acc_write_i && !xfer_en_i &&
                   (acc_addr_i < ADDR_W'(N_REGS));
  assign commit  = xfer_en_i && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else if (fire_i) begin
      if (commit) begin
        live_q <= shadow_q;
        pend_q <= 1'b0;
      end else begin
        live_q <= live_nx;
        if (xfer_en_i) shadow_q <= live_nx;
      end
    end else if (wr_time) begin
      pend_q <= 1'b1;
      if (acc_addr_i == ADDR_W'(0))
        shadow_q[FRAC_LO_W-1:0] <= acc_wdata_i[BYTE_W-1 -: FRAC_LO_W];
      if (acc_addr_i == ADDR_W'(1))
        shadow_q[FRAC_W-1:FRAC_LO_W] <= acc_wdata_i;
      for (int k = 0; k < SEC_BYTES; k++) begin
        if (acc_addr_i == ADDR_W'(k + FIRST_SEC_ADDR))
          shadow_q[FRAC_W + BYTE_W*k +: BYTE_W] <= acc_wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sqws_q <= 1'b0;
    else if (acc_fire_i && acc_write_i && acc_addr_i == ADDR_W'(0))
      sqws_q <= acc_wdata_i[0];
  end

  always_comb begin
    rd_mux = '0;
    if (acc_addr_i == ADDR_W'(0))
      rd_mux = {shadow_q[FRAC_LO_W-1:0], {(BYTE_W-FRAC_LO_W-1){1'b0}}, sqws_q};
    if (acc_addr_i == ADDR_W'(1))
      rd_mux = shadow_q[FRAC_W-1:FRAC_LO_W];
    for (int k = 0; k < SEC_BYTES; k++) begin
      if (acc_addr_i == ADDR_W'(k + FIRST_SEC_ADDR))
        rd_mux = shadow_q[FRAC_W + BYTE_W*k +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= acc_fire_i && !acc_write_i;
      if (acc_fire_i && !acc_write_i) rd_data_o <= rd_mux;
    end
  end

  assign sqws_o = sqws_q;

  AST_LIVE_HOLDS_BETWEEN_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(live_q)); // R2
  AST_LIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !commit) |=> live_q == $past(live_q) + CNT_W'($past(run_i))); // R2
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en_i && !wr_time) |=> $stable(shadow_q)); // R6
  AST_COMMIT_LOADS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && commit) |=> live_q == $past(shadow_q)); // R9
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire_i && !acc_write_i) |=> rd_valid_o); // R7
endmodule

// File: rtl/etime_core.sv
module etime_core
  import etime_pkg::*;
#(
  parameter  int unsigned CLK_MHZ   = 250,
  parameter  int unsigned GUARD_US  = 60,
  parameter  int unsigned SEC_BYTES = 4,
  localparam int unsigned LEAD      = CLK_MHZ * GUARD_US,
  localparam int unsigned ADDR_W    = $clog2(FIRST_SEC_ADDR + SEC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_fail,
  input  logic              on_batt,
  input  logic              event_in,
  input  logic [1:0]        cfg_mode,
  input  logic              event_pol,
  input  logic              xfer_en,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              uip,
  output logic              sqws
);
  logic run, fire, acc_fire;

  etime_gate u_gate (
    .mode_i      (run_mode_e'(cfg_mode)),
    .event_pol_i (event_pol),
    .event_i     (event_in),
    .pwr_fail_i  (pwr_fail),
    .on_batt_i   (on_batt),
    .run_o       (run)
  );

  etime_uip #(.LEAD(LEAD)) u_uip (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .uip_o  (uip),
    .fire_o (fire)
  );

  assign acc_ready = !fire;
  assign acc_fire  = acc_valid && acc_ready;

  etime_regs #(.SEC_BYTES(SEC_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire),
    .run_i       (run),
    .xfer_en_i   (xfer_en),
    .acc_fire_i  (acc_fire),
    .acc_write_i (acc_write),
    .acc_addr_i  (acc_addr),
    .acc_wdata_i (acc_wdata),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .sqws_o      (sqws)
  );

  AST_READY_GAP_INSIDE_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |-> uip); // R10
  AST_READY_BACK_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |=> acc_ready); // R10
endmodule

// File: tb/tb_etime_core.sv
module tb_etime_core;
  localparam int LEAD = 6;   // CLK_MHZ 2 x GUARD_US 3, shortened window
  localparam int CNT_W = 44;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic pwr_fail = 1'b0, on_batt = 1'b0, event_in = 1'b0, event_pol = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic xfer_en = 1'b0, acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic acc_ready, rd_valid, uip, sqws;
  logic [7:0] rd_data;

  etime_core #(.CLK_MHZ(2), .GUARD_US(3), .SEC_BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail), .on_batt(on_batt),
    .event_in(event_in), .cfg_mode(cfg_mode), .event_pol(event_pol), .xfer_en(xfer_en),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .uip(uip), .sqws(sqws)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [CNT_W-1:0] m_live = '0, m_shadow = '0;
  bit m_pend = 1'b0, m_sqws = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_run();
    case (cfg_mode)
      2'b00: return 1'b1;
      2'b01: return !pwr_fail && (event_in == event_pol);
      2'b10: return !on_batt;
      default: return on_batt;
    endcase
  endfunction

  // monitor: pops expected read bytes as responses appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected", {56'd0, rd_data}, 64'd0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data == e, t, {56'd0, rd_data}, {56'd0, e});
      end
    end
  end

  task automatic pulse_tick(input bit timing, input bit extra);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (timing) chk(uip == 1'b1, "R5 uip rise", {63'd0, uip}, 64'd1);
    for (int i = 1; i < LEAD; i++) begin
      @(negedge clk) tick = (extra && i == 1);
    end
    tick = 1'b0;
    if (timing) begin
      chk(uip == 1'b1, "R5 uip held", {63'd0, uip}, 64'd1);
      chk(acc_ready == 1'b0, "R10 ready gap", {63'd0, acc_ready}, 64'd0);
    end
    @(negedge clk);
    if (timing) begin
      chk(uip == 1'b0, "R5 uip fall", {63'd0, uip}, 64'd0);
      chk(acc_ready == 1'b1, "R10 ready back", {63'd0, acc_ready}, 64'd1);
    end
    if (xfer_en && m_pend) begin
      m_live = m_shadow;
      m_pend = 1'b0;
    end else begin
      m_live = m_live + CNT_W'(model_run());
      if (xfer_en) m_shadow = m_live;
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk) acc_valid = 1'b0;
  endtask

  task automatic read_time(input string t);
    rd(3'd0, {m_shadow[3:0], 3'b000, m_sqws}, t);
    rd(3'd1, m_shadow[11:4], t);
    for (int k = 0; k < 4; k++) rd(3'(k + 2), m_shadow[12 + 8*k +: 8], t);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk) acc_valid = 1'b0;
    if (a == 3'd0) m_sqws = d[0];
    if (!xfer_en && a < 3'd6) begin
      m_pend = 1'b1;
      if (a == 3'd0) m_shadow[3:0] = d[7:4];
      else if (a == 3'd1) m_shadow[11:4] = d;
      else m_shadow[12 + 8*(a-2) +: 8] = d;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL all watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(uip == 1'b0, "R1 uip", {63'd0, uip}, 64'd0);
    chk(rd_valid == 1'b0, "R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    chk(sqws == 1'b0, "R1 sqws", {63'd0, sqws}, 64'd0);
    read_time("R1 reset value");

    // R2 free running, R6 shadow follows
    xfer_en = 1'b1; cfg_mode = 2'b00; on_batt = 1'b1; pwr_fail = 1'b1;
    pulse_tick(1'b1, 1'b0);
    pulse_tick(1'b0, 1'b0);
    pulse_tick(1'b0, 1'b0);
    read_time("R2 always mode");
    rd(3'd6, 8'h00, "R7 unused address");
    rd(3'd7, 8'h00, "R7 unused address");

    // R3 event mode
    cfg_mode = 2'b01; pwr_fail = 1'b0; on_batt = 1'b0;
    event_pol = 1'b1; event_in = 1'b1; pulse_tick(1'b0, 1'b0);
    event_in = 1'b0; pulse_tick(1'b0, 1'b0);
    event_pol = 1'b0; pulse_tick(1'b0, 1'b0);
    pwr_fail = 1'b1; pulse_tick(1'b0, 1'b0);
    read_time("R3 event gating");

    // R4 power source modes
    pwr_fail = 1'b0;
    cfg_mode = 2'b10; on_batt = 1'b0; pulse_tick(1'b0, 1'b0);
    on_batt = 1'b1; pulse_tick(1'b0, 1'b0);
    cfg_mode = 2'b11; pulse_tick(1'b0, 1'b0);
    on_batt = 1'b0; pulse_tick(1'b0, 1'b0);
    read_time("R4 source gating");

    // R6 freeze then resume
    cfg_mode = 2'b00;
    xfer_en = 1'b0; pulse_tick(1'b0, 1'b0);
    read_time("R6 frozen shadow");
    xfer_en = 1'b1; pulse_tick(1'b0, 1'b0);
    read_time("R6 refreshed shadow");

    // R5 tick during busy window is dropped
    pulse_tick(1'b1, 1'b1);
    read_time("R5 dropped tick");

    // R8 write ignored while transfer enabled
    wr(3'd2, 8'hA5);
    read_time("R8 write ignored");
    pulse_tick(1'b0, 1'b0);
    read_time("R8 live untouched");

    // R8 shadow writes with transfer disabled, R12 sync bit
    xfer_en = 1'b0;
    wr(3'd0, 8'hF1);
    wr(3'd1, 8'hFF);
    for (int k = 2; k < 6; k++) wr(3'(k), 8'hFF);
    chk(sqws == 1'b1, "R12 sync set", {63'd0, sqws}, 64'd1);
    read_time("R8 shadow written");

    // R9 commit, R11 wrap
    xfer_en = 1'b1;
    pulse_tick(1'b0, 1'b0);
    read_time("R9 commit no increment");
    pulse_tick(1'b0, 1'b0);
    read_time("R11 wrap to zero");
    pulse_tick(1'b0, 1'b0);
    read_time("R9 counting after commit");

    // R12 sync bit written with transfer enabled, time unchanged
    wr(3'd0, 8'h00);
    chk(sqws == 1'b0, "R12 sync clear", {63'd0, sqws}, 64'd0);
    read_time("R12 time unaffected");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 missing responses", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule